// File: doc/BRIEF.md
# Vector Register Type Configuration File

This block holds the type descriptor of each architectural vector register together with one global element-width ceiling, and gives a core read and write access to the descriptors through a bank of configuration CSRs. Each descriptor is 16 bits wide and carries a shape field, a numeric representation field and an element-width code. The CSR view packs several descriptors into one XLEN-wide word. XLEN is a parameter and may be 32 or 64.

Each write is checked before it takes effect. A legal write updates the stored descriptors and pulses clear requests toward the vector data storage. These are a per-register clear mask and a whole-unit clear. An illegal write changes nothing and pulses an illegal-instruction flag instead. The decode and execute stages read the stored descriptors from a flat output bus. A configuration CSR write also zeroes every descriptor held by a higher-numbered CSR, so software fills the configuration from the lowest CSR upward.

Top module: `vcfg_regfile`

## Requirements
- R1: After reset every descriptor, the width ceiling, the clear mask, the clear-all pulse and the illegal flag are zero.
- R2: A descriptor holds shape in bits 15..11, representation in bits 10..6 and width code in bits 5..0. With XLEN=64, CSR address 2k holds registers 4k..4k+3, and register 4k+j sits at bits 16j+15..16j. The read port returns the stored packing. Odd addresses hold nothing: they read as zero and a write to one is illegal.
- R3: A legal write to a configuration CSR zeroes every descriptor held by a higher-numbered CSR.
- R4: A write that would leave an enabled register (width code not 0) above a disabled one is illegal.
- R5: The accepted width codes are 0 (disabled), octal 10, 20, 30 and 40. Code 40 is accepted only when ELEN is at least 64. Any other code makes the write illegal.
- R6: An illegal write leaves all stored state unchanged. It raises the illegal flag for one cycle, in the cycle after the write, and raises no clear output.
- R7: A width-ceiling write with an accepted code (including 0) stores the code and pulses clear-all in the next cycle, even when the value is unchanged. Any other code is illegal.
- R8: While the ceiling is non-zero, a write giving any register a width code above the ceiling is illegal.
- R9: While the ceiling is non-zero, a legal configuration write sets the clear-mask bit of every register it writes (the target CSR and all above it) for one cycle, even when a value is unchanged. It does not pulse clear-all.
- R10: While the ceiling is zero, a legal configuration write sets the same mask bits. It also pulses clear-all when any written register's width code changes.
- R11: When a ceiling write and a configuration write arrive in the same cycle, the ceiling write is handled and the configuration write is dropped.
- R12: In a cycle with no write, the next cycle shows no clear and no illegal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Configuration CSR write strobe |
| csr_addr | input | AW (4) | Configuration CSR index, used for read and write |
| csr_wdata | input | XLEN | Configuration CSR write data |
| csr_rdata | output | XLEN | Packed descriptors at csr_addr (combinational) |
| mew_we | input | 1 | Width-ceiling write strobe |
| mew_wdata | input | 6 | Width-ceiling write code |
| mew_q | output | 6 | Stored width ceiling |
| vtype_flat | output | NREG*16 | All descriptors, register n at bits 16n+15..16n |
| clr_mask | output | NREG | One-cycle per-register data clear |
| clr_all | output | 1 | One-cycle whole-unit data clear |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
A corrupted descriptor can be seen on the read port and on vtype_flat right after the edge that stored it. The zeroing of higher CSRs is checked by reading those CSRs after a lower one has been rewritten. A wrong legality decision or a wrong clear decision shows on illegal, clr_mask or clr_all one cycle after the write. Directed writes hit each rule at its boundary: a gap in enabled registers, an odd address, width codes just outside the accepted set, a code above the ceiling, an unchanged rewrite, and simultaneous writes.

// File: rtl/vcfg_pkg.sv
// Shared constants and helpers for the vector type configuration file.
// Assumes the base width-code set only; richer formats are decoded elsewhere.
package vcfg_pkg;
    localparam int FW  = 16;  // descriptor width
    localparam int EWW = 6;   // width-code field width

    // True when a width code is one of the accepted base codes for this ELEN.
    function automatic logic ew_legal(input logic [EWW-1:0] ew, input int elen);
        logic ok;
        ok = (ew == 6'o00) || (ew == 6'o10) || (ew == 6'o20) || (ew == 6'o30) ||
             ((ew == 6'o40) && (elen >= 64));
        return ok;
    endfunction
endpackage

// File: rtl/vcfg_wcheck.sv
// Write evaluator: builds the candidate descriptor set for a CSR write
// (target chunk replaced, higher chunks zeroed), the set of written registers,
// the legality verdict and whether any written width code changes.
// Assumes XLEN is 32 or 64 and NREG is a multiple of XLEN/16.
module vcfg_wcheck
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int ELEN = 64,
    parameter int AW   = 4
) (
    input  logic [NREG*FW-1:0] cur_flat,
    input  logic [EWW-1:0]     mew,
    input  logic [AW-1:0]      addr,
    input  logic [XLEN-1:0]    wdata,
    output logic [NREG*FW-1:0] cand_flat,
    output logic [NREG-1:0]    wr_mask,
    output logic               bad,
    output logic               width_chg
);
    localparam int RPC    = XLEN / FW;  // descriptors per CSR
    localparam int STRIDE = XLEN / 32;  // address step between used CSRs

    int  base;
    logic addr_ok;

    // Compute candidate state and verdict for a write at addr.
    always_comb begin
        logic [FW-1:0] c;
        logic [FW-1:0] p;
        addr_ok   = (int'(addr) % STRIDE) == 0;
        base      = (int'(addr) / STRIDE) * RPC;
        bad       = !addr_ok;
        width_chg = 1'b0;
        cand_flat = '0;
        wr_mask   = '0;
        for (int n = 0; n < NREG; n++) begin
            if (n >= base && n < base + RPC)
                c = wdata[(n - base)*FW +: FW];
            else if (n >= base + RPC)
                c = '0;
            else
                c = cur_flat[n*FW +: FW];
            cand_flat[n*FW +: FW] = c;
            wr_mask[n] = (n >= base);
            if (n >= base) begin
                if (!ew_legal(c[EWW-1:0], ELEN)) bad = 1'b1;
                if ((mew != '0) && (c[EWW-1:0] > mew)) bad = 1'b1;
                if (c[EWW-1:0] != cur_flat[n*FW +: EWW]) width_chg = 1'b1;
            end
        end
        // Enabled registers must form a run starting at register 0.
        for (int n = 1; n < NREG; n++) begin
            c = cand_flat[n*FW +: FW];
            p = cand_flat[(n-1)*FW +: FW];
            if ((c[EWW-1:0] != '0) && (p[EWW-1:0] == '0)) bad = 1'b1;
        end
    end
endmodule

// File: rtl/vcfg_state.sv
// Storage for descriptors, width ceiling and the one-cycle result pulses.
// Assumes the caller decides legality; this module only registers.
module vcfg_state
    import vcfg_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_vt,
    input  logic [NREG*FW-1:0] nxt_vt,
    input  logic               upd_mew,
    input  logic [EWW-1:0]     nxt_mew,
    input  logic [NREG-1:0]    mask_d,
    input  logic               all_d,
    input  logic               ill_d,
    output logic [NREG*FW-1:0] vt_q,
    output logic [EWW-1:0]     mew_q,
    output logic [NREG-1:0]    mask_q,
    output logic               all_q,
    output logic               ill_q
);
    // One register slot per descriptor.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        // Hold or load descriptor g.
        always_ff @(posedge clk) begin
            if (!rst_n)      vt_q[g*FW +: FW] <= '0;
            else if (upd_vt) vt_q[g*FW +: FW] <= nxt_vt[g*FW +: FW];
        end
    end

    // Ceiling register and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mew_q  <= '0;
            mask_q <= '0;
            all_q  <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            if (upd_mew) mew_q <= nxt_mew;
            mask_q <= mask_d;
            all_q  <= all_d;
            ill_q  <= ill_d;
        end
    end
endmodule

// File: rtl/vcfg_rdmux.sv
// Read selector: returns the packed descriptors held by a configuration CSR,
// zero for an address that holds nothing. Purely combinational.
module vcfg_rdmux
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int AW   = 4
) (
    input  logic [NREG*FW-1:0] vt,
    input  logic [AW-1:0]      addr,
    output logic [XLEN-1:0]    rdata
);
    localparam int RPC    = XLEN / FW;
    localparam int STRIDE = XLEN / 32;

    // Select one chunk of descriptors.
    always_comb begin
        int base;
        base  = (int'(addr) / STRIDE) * RPC;
        rdata = '0;
        if ((int'(addr) % STRIDE) == 0 && base < NREG)
            rdata = vt[base*FW +: XLEN];
    end
endmodule

// File: rtl/vcfg_regfile.sv
// Top of the vector type configuration file. Arbitrates ceiling and CSR
// writes (ceiling wins), applies legality and clear rules, exposes state.
// Assumes XLEN in {32,64}; one write of each kind at most per cycle.
module vcfg_regfile
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int ELEN = 64,
    localparam int AW  = $clog2(NREG*FW/32)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [AW-1:0]      csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic               mew_we,
    input  logic [EWW-1:0]     mew_wdata,
    output logic [EWW-1:0]     mew_q,
    output logic [NREG*FW-1:0] vtype_flat,
    output logic [NREG-1:0]    clr_mask,
    output logic               clr_all,
    output logic               illegal
);
    logic [NREG*FW-1:0] cand;
    logic [NREG-1:0]    wr;
    logic               bad, chg, mew_ok, upd_vt, upd_mew, ill_d, all_d;
    logic [NREG-1:0]    mask_d;

    vcfg_wcheck #(.XLEN(XLEN), .NREG(NREG), .ELEN(ELEN), .AW(AW)) u_chk_w (
        .cur_flat(vtype_flat), .mew(mew_q), .addr(csr_addr), .wdata(csr_wdata),
        .cand_flat(cand), .wr_mask(wr), .bad(bad), .width_chg(chg)
    );

    // Arbitration and effect selection for this cycle's writes.
    always_comb begin
        mew_ok  = ew_legal(mew_wdata, ELEN);
        upd_mew = mew_we && mew_ok;
        upd_vt  = !mew_we && csr_we && !bad;
        ill_d   = (mew_we && !mew_ok) || (!mew_we && csr_we && bad);
        all_d   = upd_mew || (upd_vt && (mew_q == '0) && chg);
        mask_d  = upd_vt ? wr : '0;
    end

    vcfg_state #(.NREG(NREG)) u_state (
        .clk(clk), .rst_n(rst_n),
        .upd_vt(upd_vt), .nxt_vt(cand),
        .upd_mew(upd_mew), .nxt_mew(mew_wdata),
        .mask_d(mask_d), .all_d(all_d), .ill_d(ill_d),
        .vt_q(vtype_flat), .mew_q(mew_q),
        .mask_q(clr_mask), .all_q(clr_all), .ill_q(illegal)
    );

    vcfg_rdmux #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_rd (
        .vt(vtype_flat), .addr(csr_addr), .rdata(csr_rdata)
    );
endmodule

// File: rtl/vcfg_regfile_chk.sv
// Checker for vcfg_regfile, attached by bind. Observes ports only.
module vcfg_regfile_chk #(
    parameter int NREG = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_we,
    input logic               mew_we,
    input logic [NREG*16-1:0] vtype_flat,
    input logic [5:0]         mew_q,
    input logic [NREG-1:0]    clr_mask,
    input logic               clr_all,
    input logic               illegal
);
    logic gap;

    // Detects an enabled register above a disabled one in stored state.
    always_comb begin
        gap = 1'b0;
        for (int n = 1; n < NREG; n++)
            if (vtype_flat[n*16 +: 6] != '0 && vtype_flat[(n-1)*16 +: 6] == '0)
                gap = 1'b1;
    end

    a_r6_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(vtype_flat) && $stable(mew_q)));
    a_r6_illegal_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!clr_all && clr_mask == '0));
    a_r7_mew_write_reacts: assert property (@(posedge clk) disable iff (!rst_n)
        mew_we |=> (clr_all || illegal));
    a_r11_mew_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mew_we && csr_we) |=> (clr_mask == '0));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && !mew_we) |=> (!illegal && !clr_all && clr_mask == '0));
    a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        !gap);
endmodule

bind vcfg_regfile vcfg_regfile_chk #(.NREG(NREG)) u_vcfg_chk (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .mew_we(mew_we),
    .vtype_flat(vtype_flat), .mew_q(mew_q), .clr_mask(clr_mask),
    .clr_all(clr_all), .illegal(illegal)
);

// File: tb/tb_vcfg_regfile.sv
`timescale 1ns/1ps
// Directed bench for vcfg_regfile at XLEN=64, NREG=32, ELEN=64.
module tb_vcfg_regfile;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         csr_we = 1'b0;
    logic [3:0]   csr_addr = '0;
    logic [63:0]  csr_wdata = '0;
    logic [63:0]  csr_rdata;
    logic         mew_we = 1'b0;
    logic [5:0]   mew_wdata = '0;
    logic [5:0]   mew_q;
    logic [511:0] vtype_flat;
    logic [31:0]  clr_mask;
    logic         clr_all;
    logic         illegal;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vcfg_regfile dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mew_we(mew_we),
        .mew_wdata(mew_wdata), .mew_q(mew_q), .vtype_flat(vtype_flat),
        .clr_mask(clr_mask), .clr_all(clr_all), .illegal(illegal)
    );

    function automatic logic [15:0] fld(input logic [5:0] ew);
        return {5'b00100, 5'd1, ew};
    endfunction

    function automatic logic [63:0] pk(input logic [5:0] e0, e1, e2, e3);
        return {fld(e3), fld(e2), fld(e1), fld(e0)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; outputs sampled at the following falling edge.
    task automatic wr(input bit dc, input logic [3:0] a, input logic [63:0] d,
                      input bit dm, input logic [5:0] m);
        @(negedge clk);
        csr_we = dc; csr_addr = a; csr_wdata = d; mew_we = dm; mew_wdata = m;
        @(negedge clk);
        csr_we = 1'b0; mew_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        csr_addr = a; #0.1; d = csr_rdata;
    endtask

    task automatic expect_pulses(input string req, input logic [31:0] m,
                                 input logic a, input logic i);
        chk({req, " mask"}, 64'(clr_mask), 64'(m));
        chk({req, " all"}, 64'(clr_all), 64'(a));
        chk({req, " illegal"}, 64'(illegal), 64'(i));
    endtask

    task automatic t_reset();
        chk("R1 types", 64'(vtype_flat != '0), 64'd0);
        chk("R1 mew", 64'(mew_q), 64'd0);
        expect_pulses("R1", 32'd0, 1'b0, 1'b0);
    endtask

    task automatic t_pack_and_zero();
        logic [63:0] d;
        wr(1, 4'd0, pk(6'o10, 6'o10, 6'o20, 6'o00), 0, 6'd0);
        expect_pulses("R10 first write", 32'hFFFF_FFFF, 1'b1, 1'b0);
        rd(4'd0, d); chk("R2 readback", d, pk(6'o10, 6'o10, 6'o20, 6'o00));
        chk("R2 reg2 field", 64'(vtype_flat[47:32]), 64'(16'b00100_00001_010000));
        wr(1, 4'd2, pk(6'o20, 6'o20, 6'o20, 6'o20), 0, 6'd0);
        expect_pulses("R4 gap", 32'd0, 1'b0, 1'b1);
        rd(4'd2, d); chk("R4 unchanged", d, 64'd0);
        wr(1, 4'd0, pk(6'o10, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R10 change", 32'hFFFF_FFFF, 1'b1, 1'b0);
        wr(1, 4'd2, pk(6'o20, 6'o20, 6'o20, 6'o20), 0, 6'd0);
        expect_pulses("R10 upper", 32'hFFFF_FFF0, 1'b1, 1'b0);
        rd(4'd2, d); chk("R2 upper readback", d, pk(6'o20, 6'o20, 6'o20, 6'o20));
        chk("R2 flat upper", vtype_flat[127:64], pk(6'o20, 6'o20, 6'o20, 6'o20));
        wr(1, 4'd0, pk(6'o10, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        rd(4'd2, d); chk("R3 higher zeroed", d, 64'd0);
        chk("R10 higher change", 64'(clr_all), 64'd1);
        wr(1, 4'd0, pk(6'o10, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R10 same", 32'hFFFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_widths();
        logic [63:0] d;
        wr(1, 4'd0, pk(6'o11, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R5 code 11", 32'd0, 1'b0, 1'b1);
        rd(4'd0, d); chk("R6 state kept", d, pk(6'o10, 6'o10, 6'o10, 6'o10));
        wr(1, 4'd0, pk(6'o10, 6'o50, 6'o10, 6'o10), 0, 6'd0);
        chk("R5 code 50", 64'(illegal), 64'd1);
        wr(1, 4'd0, pk(6'o40, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        chk("R5 code 40", 64'(illegal), 64'd0);
        rd(4'd0, d); chk("R5 code 40 stored", d, pk(6'o40, 6'o10, 6'o10, 6'o10));
        wr(1, 4'd1, pk(6'o10, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R2 odd write", 32'd0, 1'b0, 1'b1);
        rd(4'd1, d); chk("R2 odd read", d, 64'd0);
        rd(4'd0, d); chk("R6 odd kept", d, pk(6'o40, 6'o10, 6'o10, 6'o10));
    endtask

    task automatic t_ceiling();
        logic [63:0] d;
        wr(0, 4'd0, 64'd0, 1, 6'o20);
        expect_pulses("R7 set", 32'd0, 1'b1, 1'b0);
        chk("R7 stored", 64'(mew_q), 64'(6'o20));
        wr(0, 4'd0, 64'd0, 1, 6'o20);
        chk("R7 same value", 64'(clr_all), 64'd1);
        wr(0, 4'd0, 64'd0, 1, 6'o13);
        expect_pulses("R7 bad code", 32'd0, 1'b0, 1'b1);
        chk("R7 kept", 64'(mew_q), 64'(6'o20));
        wr(1, 4'd0, pk(6'o40, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R8 above", 32'd0, 1'b0, 1'b1);
        wr(1, 4'd0, pk(6'o10, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R9 change", 32'hFFFF_FFFF, 1'b0, 1'b0);
        wr(1, 4'd0, pk(6'o10, 6'o10, 6'o10, 6'o10), 0, 6'd0);
        expect_pulses("R9 same", 32'hFFFF_FFFF, 1'b0, 1'b0);
        rd(4'd0, d); chk("R9 stored", d, pk(6'o10, 6'o10, 6'o10, 6'o10));
    endtask

    task automatic t_both_and_idle();
        logic [63:0] d;
        wr(1, 4'd0, pk(6'o20, 6'o20, 6'o20, 6'o20), 1, 6'o10);
        expect_pulses("R11 both", 32'd0, 1'b1, 1'b0);
        chk("R11 mew", 64'(mew_q), 64'(6'o10));
        rd(4'd0, d); chk("R11 csr dropped", d, pk(6'o10, 6'o10, 6'o10, 6'o10));
        @(negedge clk);
        expect_pulses("R12 idle", 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack_and_zero();
        t_widths();
        t_ceiling();
        t_both_and_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule